// File: doc/BRIEF.md
# In-Band Interrupt Admission and Event-Disable Sequencer

This block sits in the controller side of an I3C bus. When a target wins arbitration and presents an in-band interrupt (IBI) header, the block decides whether the controller accepts or rejects it. The header is placed in one of three classes. A header from the reserved hot-join address is a hot-join. A write-direction header from a device is a controller-role request. A read-direction header from a device is a target interrupt. A header whose source is the broadcast address cannot be classified. For device headers the block searches a small table of dynamic addresses, which holds two reject flags per entry.

The block returns a one-cycle decision pulse with an accept bit. It also provides the identifier and rejected-status bits of the status word, and a notify flag. The notify flag tells downstream queue logic to report the event even when it was rejected. After the enclosing transfer logic signals that the IBI has finished, a rejection that calls for it is followed by a disable-events command (DISEC). The command leaves as a short sequence of START and data transfers on a valid/ready transmit interface. A hot-join rejection uses the broadcast form. A rejected device request uses the direct form, addressed to the requester. The event byte matches the class of the request. When the sequence ends, all held state is cleared.

Top module: `ibi_policy_seq`

## Requirements
- R1: After reset and whenever `busy` is low, `dec_ack`, `stat_nak`, `notify`, `tx_valid`, `dec_valid` and `stat_id` are all zero.
- R2: `stat_id` equals {header address[6:0], RnW}. It holds that value from the cycle after the header is accepted until the IBI is cleared.
- R3: A header from address 7'h02 (either direction) is a hot-join. With `hj_nack_en`=1 it is rejected with `stat_nak`=1, and a broadcast DISEC with event byte 8'h08 follows. With `hj_nack_en`=0 it is accepted and no DISEC follows.
- R4: A write-direction device header whose table entry has its controller-request reject flag set is rejected with `stat_nak`=1. A direct DISEC with event byte 8'h02 is then sent to that address.
- R5: A read-direction device header whose table entry has its interrupt reject flag set is rejected with `stat_nak`=1. A direct DISEC with event byte 8'h01 is then sent to that address.
- R6: A device header whose matching entry has the reject flag for its class clear is accepted (`dec_ack`=1, `stat_nak`=0), and no DISEC follows.
- R7: The lookup checks entries 0 upward, one per clock, and the first match wins. Only entries below min(`tbl_count`, DEPTH) take part. A hit at index k raises `dec_valid` k+2 sampling points after the header edge, and a miss raises it `tbl_count`+2 points after. Hot-join and unclassifiable headers decide after 1 point. `dec_valid` lasts one cycle.
- R8: A device address with no matching entry is rejected with `stat_nak`=0, and no DISEC follows.
- R9: A header from address 7'h7E is rejected with `stat_nak`=0 and `notify`=0, and no DISEC follows.
- R10: `notify` equals the enable for the class of the request: `ntf_hj_en` for hot-join, `ntf_cr_en` for write-direction and `ntf_ti_en` for read-direction device headers, whether or not the device was found.
- R11: A DISEC is sent as ordered transfers, where `tx_start`=1 marks a START carrying {address, 0}. The order is: START 8'hFC, then data 8'h01 (broadcast) or 8'h81 (direct); in direct mode START {target, 0} comes next; the event byte is always last.
- R12: While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_start` and `tx_data` hold.
- R13: `ibi_done` after the decision clears the IBI at once, or after the final DISEC transfer, and `busy` then falls. A `hdr_valid` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | IBI header present (sampled while idle) |
| hdr_addr | input | 7 | Arbitrated source address |
| hdr_rnw | input | 1 | Direction bit of the header |
| hj_nack_en | input | 1 | Reject hot-joins and disable them |
| ntf_hj_en | input | 1 | Report rejected hot-joins |
| ntf_cr_en | input | 1 | Report rejected controller-role requests |
| ntf_ti_en | input | 1 | Report rejected target interrupts |
| tbl_count | input | $clog2(DEPTH+1) | Number of valid table entries |
| tbl_dyn_addr | input | 7*DEPTH | Dynamic address of entry i at bits [7i+6:7i] |
| tbl_cr_rej | input | DEPTH | Per-entry controller-request reject flag |
| tbl_ti_rej | input | DEPTH | Per-entry interrupt reject flag |
| ibi_done | input | 1 | IBI transfer finished |
| tx_ready | input | 1 | Transmit side takes the current transfer |
| busy | output | 1 | An IBI is held |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_ack | output | 1 | Decision: accept |
| stat_id | output | 8 | Status identifier {address, RnW} |
| stat_nak | output | 1 | Rejected-status bit |
| notify | output | 1 | Report even if rejected |
| tx_valid | output | 1 | Transfer request |
| tx_start | output | 1 | Transfer is a START with address byte |
| tx_data | output | 8 | Address byte or data byte |

## Verification
The bench uses the default DEPTH of 8 with five valid entries. The five entries include a duplicate address behind an earlier match, and the slots beyond the count are filled with reject-flagged entries. This brings shadowing, the count limit and the miss latency within reach. Separate runs set `tbl_count` to 0 and to 15. The second case exercises clamping to DEPTH, which only a parameter smaller than the count width's range can show. A stalled transmit side and a header arriving mid-IBI complete the corner cases.

// File: rtl/ibi_policy_pkg.sv
package ibi_policy_pkg;

    localparam logic [6:0] HJ_ADDR       = 7'h02;
    localparam logic [6:0] BCAST_ADDR    = 7'h7E;
    localparam logic [7:0] CCC_DISEC_BC  = 8'h01;
    localparam logic [7:0] CCC_DISEC_DIR = 8'h81;
    localparam logic [7:0] EVT_HJ        = 8'h08;
    localparam logic [7:0] EVT_CR        = 8'h02;
    localparam logic [7:0] EVT_TI        = 8'h01;

    typedef enum logic [1:0] {K_HJ, K_CR, K_TI, K_BAD} ibi_kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_HOLD, ST_SEND} seq_state_e;

    typedef struct packed {
        logic       ack;
        logic       nak;
        logic       ntf;
        logic       go;
        logic       direct;
        logic [7:0] evt;
    } verdict_t;

    function automatic ibi_kind_e classify(input logic [6:0] a, input logic rnw);
        if (a == HJ_ADDR)         return K_HJ;
        else if (a == BCAST_ADDR) return K_BAD;
        else if (rnw)             return K_TI;
        else                      return K_CR;
    endfunction

    function automatic logic [7:0] addr_wr(input logic [6:0] a);
        return {a, 1'b0};
    endfunction

endpackage

// File: rtl/ibi_tbl_scan.sv
module ibi_tbl_scan #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]      idx,
    input  logic [CW-1:0]      cnt,
    input  logic [6:0]         key,
    input  logic [DEPTH*7-1:0] dyn_addr,
    input  logic [DEPTH-1:0]   cr_rej,
    input  logic [DEPTH-1:0]   ti_rej,
    output logic               past_end,
    output logic               hit,
    output logic               hit_cr_rej,
    output logic               hit_ti_rej
);
    logic [CW-1:0]    eff_cnt;
    logic [DEPTH-1:0] match;

    assign eff_cnt = (cnt > CW'(DEPTH)) ? CW'(DEPTH) : cnt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (dyn_addr[g*7 +: 7] == key);
    end

    always_comb begin
        past_end   = (idx >= eff_cnt);
        hit        = 1'b0;
        hit_cr_rej = 1'b0;
        hit_ti_rej = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == CW'(i) && !past_end) begin
                hit        = match[i];
                hit_cr_rej = cr_rej[i];
                hit_ti_rej = ti_rej[i];
            end
        end
    end
endmodule

// File: rtl/ibi_verdict.sv
module ibi_verdict
    import ibi_policy_pkg::*;
(
    input  ibi_kind_e kind,
    input  logic      hj_nack_en,
    input  logic      ntf_hj_en,
    input  logic      ntf_cr_en,
    input  logic      ntf_ti_en,
    input  logic      hit,
    input  logic      hit_cr_rej,
    input  logic      hit_ti_rej,
    output verdict_t  vd
);
    always_comb begin
        vd = '0;
        case (kind)
            K_HJ: begin
                vd.ntf = ntf_hj_en;
                if (hj_nack_en) begin
                    vd.nak = 1'b1;
                    vd.go  = 1'b1;
                    vd.evt = EVT_HJ;
                end else begin
                    vd.ack = 1'b1;
                end
            end
            K_CR: begin
                vd.ntf = ntf_cr_en;
                if (hit && hit_cr_rej) begin
                    vd.nak    = 1'b1;
                    vd.go     = 1'b1;
                    vd.direct = 1'b1;
                    vd.evt    = EVT_CR;
                end else if (hit) begin
                    vd.ack = 1'b1;
                end
            end
            K_TI: begin
                vd.ntf = ntf_ti_en;
                if (hit && hit_ti_rej) begin
                    vd.nak    = 1'b1;
                    vd.go     = 1'b1;
                    vd.direct = 1'b1;
                    vd.evt    = EVT_TI;
                end else if (hit) begin
                    vd.ack = 1'b1;
                end
            end
            default: vd = '0;
        endcase
    end
endmodule

// File: rtl/disec_emitter.sv
module disec_emitter
    import ibi_policy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       direct,
    input  logic [6:0] tgt,
    input  logic [7:0] evt,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic       tx_start,
    output logic [7:0] tx_data,
    output logic       done
);
    logic [1:0] step;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            step <= 2'd0;
        end else if (tx_ready) begin
            step <= (step == 2'd1 && !direct) ? 2'd3 : step + 2'd1;
        end
    end

    always_comb begin
        tx_valid = active;
        tx_start = 1'b0;
        tx_data  = 8'h00;
        case (step)
            2'd0: begin tx_start = 1'b1; tx_data = addr_wr(BCAST_ADDR); end
            2'd1: tx_data = direct ? CCC_DISEC_DIR : CCC_DISEC_BC;
            2'd2: begin tx_start = 1'b1; tx_data = addr_wr(tgt); end
            default: tx_data = evt;
        endcase
    end

    assign done = active && tx_ready && (step == 2'd3);
endmodule

// File: rtl/ibi_policy_seq.sv
module ibi_policy_seq
    import ibi_policy_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hdr_valid,
    input  logic [6:0]         hdr_addr,
    input  logic               hdr_rnw,
    input  logic               hj_nack_en,
    input  logic               ntf_hj_en,
    input  logic               ntf_cr_en,
    input  logic               ntf_ti_en,
    input  logic [CW-1:0]      tbl_count,
    input  logic [DEPTH*7-1:0] tbl_dyn_addr,
    input  logic [DEPTH-1:0]   tbl_cr_rej,
    input  logic [DEPTH-1:0]   tbl_ti_rej,
    input  logic               ibi_done,
    input  logic               tx_ready,
    output logic               busy,
    output logic               dec_valid,
    output logic               dec_ack,
    output logic [7:0]         stat_id,
    output logic               stat_nak,
    output logic               notify,
    output logic               tx_valid,
    output logic               tx_start,
    output logic [7:0]         tx_data
);
    seq_state_e    state;
    logic [6:0]    key;
    logic          key_rnw;
    ibi_kind_e     kind_q;
    ibi_kind_e     kind_in;
    ibi_kind_e     vd_kind;
    logic [CW-1:0] idx;
    verdict_t      held;
    verdict_t      vd;
    logic          dec_pulse;
    logic          past_end, hit, hit_cr_rej, hit_ti_rej;
    logic          tx_done;

    assign kind_in = classify(hdr_addr, hdr_rnw);
    assign vd_kind = (state == ST_SCAN) ? kind_q : kind_in;

    ibi_tbl_scan #(.DEPTH(DEPTH)) u_scan (
        .idx        (idx),
        .cnt        (tbl_count),
        .key        (key),
        .dyn_addr   (tbl_dyn_addr),
        .cr_rej     (tbl_cr_rej),
        .ti_rej     (tbl_ti_rej),
        .past_end   (past_end),
        .hit        (hit),
        .hit_cr_rej (hit_cr_rej),
        .hit_ti_rej (hit_ti_rej)
    );

    ibi_verdict u_verdict (
        .kind       (vd_kind),
        .hj_nack_en (hj_nack_en),
        .ntf_hj_en  (ntf_hj_en),
        .ntf_cr_en  (ntf_cr_en),
        .ntf_ti_en  (ntf_ti_en),
        .hit        (hit && state == ST_SCAN),
        .hit_cr_rej (hit_cr_rej),
        .hit_ti_rej (hit_ti_rej),
        .vd         (vd)
    );

    disec_emitter u_emit (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_SEND),
        .direct   (held.direct),
        .tgt      (key),
        .evt      (held.evt),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_start (tx_start),
        .tx_data  (tx_data),
        .done     (tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            key       <= '0;
            key_rnw   <= 1'b0;
            kind_q    <= K_BAD;
            idx       <= '0;
            held      <= '0;
            dec_pulse <= 1'b0;
        end else begin
            dec_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hdr_valid) begin
                        key     <= hdr_addr;
                        key_rnw <= hdr_rnw;
                        kind_q  <= kind_in;
                        idx     <= '0;
                        if (kind_in == K_HJ || kind_in == K_BAD) begin
                            held      <= vd;
                            dec_pulse <= 1'b1;
                            state     <= ST_HOLD;
                        end else begin
                            state <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (past_end || hit) begin
                        held      <= vd;
                        dec_pulse <= 1'b1;
                        state     <= ST_HOLD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (ibi_done) begin
                        if (held.go) begin
                            state <= ST_SEND;
                        end else begin
                            state   <= ST_IDLE;
                            held    <= '0;
                            key     <= '0;
                            key_rnw <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (tx_done) begin
                        state   <= ST_IDLE;
                        held    <= '0;
                        key     <= '0;
                        key_rnw <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign dec_valid = dec_pulse;
    assign dec_ack   = held.ack;
    assign stat_nak  = held.nak;
    assign notify    = held.ntf;
    assign stat_id   = {key, key_rnw};
endmodule

// File: rtl/ibi_policy_seq_chk.sv
module ibi_policy_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       dec_valid,
    input logic       dec_ack,
    input logic [7:0] stat_id,
    input logic       stat_nak,
    input logic       notify,
    input logic       tx_valid,
    input logic       tx_start,
    input logic [7:0] tx_data,
    input logic       tx_ready
);
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stat_id == 8'h00 && !stat_nak && !notify && !dec_ack && !tx_valid && !dec_valid));

    p_id_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(stat_id));

    p_hj_reject_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && stat_id[7:1] == 7'h02 && !dec_ack) |-> stat_nak);

    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    p_nak_excl_r8: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> !(dec_ack && stat_nak));

    p_bcast_src_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && stat_id[7:1] == 7'h7E) |-> (!dec_ack && !notify && !stat_nak));

    p_first_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_start && tx_data == 8'hFC));

    p_stall_r12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_start)));

    p_tx_busy_r13: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);
endmodule

bind ibi_policy_seq ibi_policy_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .dec_valid (dec_valid),
    .dec_ack   (dec_ack),
    .stat_id   (stat_id),
    .stat_nak  (stat_nak),
    .notify    (notify),
    .tx_valid  (tx_valid),
    .tx_start  (tx_start),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
);

// File: tb/ibi_policy_seq_test.sv
`timescale 1ns/1ps
module ibi_policy_seq_test;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [6:0] a;
        logic       rnw;
        logic       hjn;
        logic [2:0] ntf;   // {hj, cr, ti}
        logic       ack;
        logic       nak;
        logic       nf;
        logic [3:0] lat;
        logic [2:0] ntx;
        logic       dir;
        logic [7:0] evt;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{7'h02, 1'b0, 1'b1, 3'b100, 1'b0, 1'b1, 1'b1, 4'd1, 3'd3, 1'b0, 8'h08},
        '{7'h02, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 4'd1, 3'd0, 1'b0, 8'h00},
        '{7'h10, 1'b0, 1'b0, 3'b010, 1'b1, 1'b0, 1'b1, 4'd2, 3'd0, 1'b0, 8'h00},
        '{7'h11, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd3, 3'd4, 1'b1, 8'h02},
        '{7'h11, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 4'd3, 3'd0, 1'b0, 8'h00},
        '{7'h12, 1'b1, 1'b0, 3'b001, 1'b0, 1'b1, 1'b1, 4'd4, 3'd4, 1'b1, 8'h01},
        '{7'h10, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 1'b1, 4'd2, 3'd0, 1'b0, 8'h00},
        '{7'h30, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 4'd7, 3'd0, 1'b0, 8'h00},
        '{7'h7E, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 4'd1, 3'd0, 1'b0, 8'h00},
        '{7'h21, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd6, 3'd4, 1'b1, 8'h01}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               hdr_valid = 1'b0;
    logic [6:0]         hdr_addr = '0;
    logic               hdr_rnw = 1'b0;
    logic               hj_nack_en = 1'b0;
    logic               ntf_hj_en = 1'b0;
    logic               ntf_cr_en = 1'b0;
    logic               ntf_ti_en = 1'b0;
    logic [CW-1:0]      tbl_count = CW'(5);
    logic [DEPTH*7-1:0] tbl_dyn_addr;
    logic [DEPTH-1:0]   tbl_cr_rej;
    logic [DEPTH-1:0]   tbl_ti_rej;
    logic               ibi_done = 1'b0;
    logic               tx_ready = 1'b1;
    logic               busy, dec_valid, dec_ack, stat_nak, notify;
    logic               tx_valid, tx_start;
    logic [7:0]         stat_id, tx_data;

    int checks = 0;
    int errors = 0;
    string tags [10];

    always #2.5 clk = ~clk;

    ibi_policy_seq #(.DEPTH(DEPTH)) uut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_ibi(input vec_t v, input string tag, input bit stall);
        int lat;
        int n;
        logic [8:0] exp_tx;
        @(negedge clk);
        hdr_valid  = 1'b1;
        hdr_addr   = v.a;
        hdr_rnw    = v.rnw;
        hj_nack_en = v.hjn;
        {ntf_hj_en, ntf_cr_en, ntf_ti_en} = v.ntf;
        @(negedge clk);
        hdr_valid = 1'b0;
        lat = 1;
        while (!dec_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(tag, "decision latency (R7)", lat, v.lat);
        chk(tag, "dec_ack", dec_ack, v.ack);
        chk(tag, "stat_nak", stat_nak, v.nak);
        chk(tag, "notify (R10)", notify, v.nf);
        chk(tag, "stat_id (R2)", stat_id, {v.a, v.rnw});
        if (stall) tx_ready = 1'b0;
        ibi_done = 1'b1;
        @(negedge clk);
        ibi_done = 1'b0;
        if (stall) begin
            for (int s = 0; s < 3; s++) begin
                chk("R12", "stalled transfer", {tx_valid, tx_start, tx_data}, {2'b11, 8'hFC});
                @(negedge clk);
            end
            tx_ready = 1'b1;
        end
        n = 0;
        while (tx_valid && n < 8) begin
            case (n)
                0: exp_tx = {1'b1, 8'hFC};
                1: exp_tx = {1'b0, v.dir ? 8'h81 : 8'h01};
                2: exp_tx = v.dir ? {1'b1, v.a, 1'b0} : {1'b0, v.evt};
                default: exp_tx = {1'b0, v.evt};
            endcase
            chk({tag, " R11"}, $sformatf("transfer %0d", n), {tx_start, tx_data}, exp_tx);
            @(negedge clk);
            n++;
        end
        chk(tag, "transfer count (R11)", n, v.ntx);
        chk("R13", "cleared after completion", {busy, stat_id, stat_nak, notify, dec_ack},
            {1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tags = '{"R3", "R3", "R6", "R4", "R6", "R5", "R7", "R8", "R9", "R5"};
        // entries: 0x10 ok, 0x11 cr-rej, 0x12 ti-rej, 0x10 both-rej (shadowed), 0x21 both-rej,
        // 5..7: 0x30 both-rej, beyond the default count of 5
        tbl_dyn_addr = {7'h30, 7'h30, 7'h30, 7'h21, 7'h10, 7'h12, 7'h11, 7'h10};
        tbl_cr_rej   = 8'b1111_1010;
        tbl_ti_rej   = 8'b1111_1100;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset outputs", {busy, dec_valid, dec_ack, stat_id, stat_nak, notify, tx_valid},
            14'h0);

        for (int i = 0; i < 10; i++) do_ibi(VECS[i], tags[i], 1'b0);

        // R12: stalled transmit side on a direct DISEC
        do_ibi(VECS[3], "R12", 1'b1);

        // R7: empty table, every device address misses after 2 points
        tbl_count = CW'(0);
        do_ibi('{7'h10, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 4'd2, 3'd0, 1'b0, 8'h00}, "R7", 1'b0);

        // R7: count above DEPTH clamps, entry 5 (0x30, ti-rej) is found
        tbl_count = CW'(15);
        do_ibi('{7'h30, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd7, 3'd4, 1'b1, 8'h01}, "R7", 1'b0);
        tbl_count = CW'(5);

        // R13: header during a held IBI is ignored
        @(negedge clk);
        hdr_valid = 1'b1; hdr_addr = 7'h10; hdr_rnw = 1'b0;
        {ntf_hj_en, ntf_cr_en, ntf_ti_en} = 3'b000; hj_nack_en = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        repeat (2) @(negedge clk);
        hdr_valid = 1'b1; hdr_addr = 7'h02;
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        chk("R13", "held id after ignored header", stat_id, 8'h20);
        chk("R13", "held accept after ignored header", {dec_ack, stat_nak}, 2'b10);
        ibi_done = 1'b1;
        @(negedge clk);
        ibi_done = 1'b0;
        chk("R13", "no DISEC after accepted IBI", tx_valid, 1'b0);
        chk("R13", "idle after done", {busy, stat_id}, 9'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule